// File: doc/BRIEF.md
# Serial keyboard command responder

This block plays the device end of a serial keyboard that sits on one channel of a serial controller. The host side sends command bytes; the block answers by loading reply bytes into a 256-byte receive queue, which the host drains one byte per read. Separately, raw key events from a scanner enter the block. Each event is mapped to a keyboard code through one of two small computed tables and appended to the same queue.

An escape byte selects the alternate table for the one key that follows it. Caps-lock and num-lock events pass through a two-bit filter, so a toggling lock key reports only its first press and its second release. One command makes the next command byte an argument that is swallowed. Reset and layout commands discard anything still queued before they load their canned answers.

A flag toward the host is high while the queue holds data. The head byte is always visible on the read data port, and a read strobe consumes it.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset the queue is empty, `byte_avail` is 0, `rd_data` is 0x00, and the LED-argument flag, the escape flag and both lock modes are cleared.
- R2: An accepted command 0x01 empties the queue and then enqueues 0xFF, 0x04, 0x7F in that order.
- R3: An accepted command 0x07 or 0x0F empties the queue and then enqueues 0xFE followed by 0x00.
- R4: An accepted command 0x0E arms an argument flag. The next accepted command byte is then discarded whatever its value, and the flag is cleared.
- R5: Any other accepted command value leaves the queue unchanged. A command strobe while `tx_en` is 0 is not accepted and has no effect.
- R6: The queue holds 256 bytes. A byte pushed while it is full is dropped. A read while it is empty returns 0x00 and changes nothing.
- R7: `byte_avail` is high exactly when the queue is non-empty. `rd_data` shows the oldest byte, and `rd_pop` removes one byte per cycle in arrival order.
- R8: A key byte k (other than 0xE0) with no escape pending enqueues {k[7], (k[6:0]*5 + 3) mod 128}; bit 7 marks a release and is preserved.
- R9: Key byte 0xE0 enqueues nothing and sets the escape flag. The next enqueued key uses {k[7], (k[6:0]*3 + 0x11) mod 128} and clears the flag.
- R10: Caps-lock uses raw codes 0x3A (press) and 0xBA (release); num-lock uses 0x45 and 0xC5. Each lock key has a two-bit mode: a press flips bit 0, a release flips bit 1. The event is dropped when the mode becomes 2 after a press or 3 after a release.
- R11: When a command and a key event arrive in the same cycle, the command is applied first, so the key code lands after any reply bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Host transmit enable; commands are accepted only while high |
| cmd_valid | input | 1 | Command byte strobe from the host |
| cmd_byte | input | 8 | Command byte |
| key_valid | input | 1 | Raw key event strobe |
| key_byte | input | 8 | Raw key code, bit 7 set on release |
| rd_pop | input | 1 | Host read strobe; consumes the head byte |
| rd_data | output | 8 | Head byte of the queue, 0x00 when empty |
| byte_avail | output | 1 | High while the queue is non-empty |

## Verification
Commands, key events and reads are all taken at one rising edge. Their effect on `byte_avail` and on the head byte shown on `rd_data` is due right after that same edge, with no further pipeline stage. `rd_data` is combinational from the head, so the value a read returns is the one present before the edge that consumes it. The bench drives every input on the falling edge and compares both outputs one nanosecond later against a queue model it updates after each rising edge. Each comparison therefore sees the result of exactly the previous edge.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;

    typedef logic [7:0] byte_t;

    localparam int unsigned REPLY_MAX = 3;
    localparam int unsigned RN_W      = $clog2(REPLY_MAX + 1);
    localparam int unsigned LOCKS     = 2;

    // host commands
    localparam byte_t CMD_RESET    = 8'h01;
    localparam byte_t CMD_LAYOUT_A = 8'h07;
    localparam byte_t CMD_LED      = 8'h0E;
    localparam byte_t CMD_LAYOUT_B = 8'h0F;

    // raw key codes with special handling
    localparam byte_t RAW_PREFIX = 8'hE0;
    localparam byte_t CAPS_DN    = 8'h3A;
    localparam byte_t CAPS_UP    = 8'hBA;
    localparam byte_t NUM_DN     = 8'h45;
    localparam byte_t NUM_UP     = 8'hC5;

    // computed translation tables
    localparam int unsigned STD_MUL = 5;
    localparam int unsigned STD_ADD = 3;
    localparam int unsigned EXT_MUL = 3;
    localparam int unsigned EXT_ADD = 17;

    typedef struct packed {
        logic                          flush;
        logic [RN_W-1:0]               n;
        logic [REPLY_MAX-1:0][7:0]     bytes;
    } reply_t;

    typedef struct packed {
        logic  valid;
        byte_t code;
    } keyout_t;

    function automatic logic [6:0] key_map(input logic [6:0] c, input logic ext);
        logic [13:0] acc;
        if (ext) acc = ({7'd0, c} * 14'(EXT_MUL)) + 14'(EXT_ADD);
        else     acc = ({7'd0, c} * 14'(STD_MUL)) + 14'(STD_ADD);
        return acc[6:0];
    endfunction

endpackage

// File: rtl/kbd_cmd_decode.sv
module kbd_cmd_decode
    import kbd_resp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    input  byte_t  cmd,
    output reply_t rep
);
    logic led_arg_q;

    always_comb begin
        rep = '0;
        if (go && !led_arg_q) begin
            unique case (cmd)
                CMD_RESET: begin
                    rep.flush = 1'b1;
                    rep.n     = RN_W'(3);
                    rep.bytes = {8'h7F, 8'h04, 8'hFF};
                end
                CMD_LAYOUT_A, CMD_LAYOUT_B: begin
                    rep.flush = 1'b1;
                    rep.n     = RN_W'(2);
                    rep.bytes = {8'h00, 8'h00, 8'hFE};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     led_arg_q <= 1'b0;
        else if (go) led_arg_q <= led_arg_q ? 1'b0 : (cmd == CMD_LED);
    end

    p_led_swallow_r4: assert property (@(posedge clk) disable iff (rst)
        (go && led_arg_q) |-> (!rep.flush && rep.n == '0));
    p_led_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (go && led_arg_q) |=> !led_arg_q);

endmodule

// File: rtl/kbd_key_xlate.sv
module kbd_key_xlate
    import kbd_resp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid,
    input  byte_t   raw,
    output keyout_t kout
);
    localparam byte_t LOCK_DN [LOCKS] = '{CAPS_DN, NUM_DN};
    localparam byte_t LOCK_UP [LOCKS] = '{CAPS_UP, NUM_UP};

    logic             ext_q;
    logic [LOCKS-1:0] lock_drop;
    logic             is_prefix;

    assign is_prefix  = (raw == RAW_PREFIX);
    assign kout.valid = valid && !is_prefix && !(|lock_drop);
    assign kout.code  = {raw[7], key_map(raw[6:0], ext_q)};

    for (genvar g = 0; g < LOCKS; g++) begin : g_lock
        logic [1:0] mode_q, mode_d;
        logic       drop_l;

        always_comb begin
            mode_d = mode_q;
            drop_l = 1'b0;
            if (valid && raw == LOCK_DN[g]) begin
                mode_d = mode_q ^ 2'b01;
                drop_l = (mode_d == 2'd2);
            end else if (valid && raw == LOCK_UP[g]) begin
                mode_d = mode_q ^ 2'b10;
                drop_l = (mode_d == 2'd3);
            end
        end

        assign lock_drop[g] = drop_l;

        always_ff @(posedge clk) begin
            if (rst) mode_q <= 2'd0;
            else     mode_q <= mode_d;
        end

        p_lock_dup_up_r10: assert property (@(posedge clk) disable iff (rst)
            (valid && raw == LOCK_UP[g] && mode_q == 2'd1) |-> !kout.valid);
        p_lock_dup_dn_r10: assert property (@(posedge clk) disable iff (rst)
            (valid && raw == LOCK_DN[g] && mode_q == 2'd3) |-> !kout.valid);
    end

    always_ff @(posedge clk) begin
        if (rst)                         ext_q <= 1'b0;
        else if (valid && is_prefix)     ext_q <= 1'b1;
        else if (kout.valid)             ext_q <= 1'b0;
    end

    p_prefix_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && is_prefix) |-> !kout.valid);
    p_prefix_arms_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && is_prefix) |=> ext_q);

endmodule

// File: rtl/kbd_byte_queue.sv
module kbd_byte_queue #(
    parameter int unsigned DEPTH    = 256,
    parameter int unsigned PUSH_MAX = 4,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned PW = $clog2(PUSH_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     pop,
    input  logic [PW-1:0]            push_n,
    input  logic [PUSH_MAX-1:0][7:0] push_data,
    output logic [7:0]               rd_data,
    output logic                     avail
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rptr, wptr, rptr_mid, wbase;
    logic [CW-1:0] count, count_mid, free, n_acc;
    logic          pop_eff;

    always_comb begin
        pop_eff   = pop && (count != '0);
        count_mid = flush ? '0 : count - CW'(pop_eff);
        rptr_mid  = flush ? '0 : rptr + AW'(pop_eff);
        wbase     = flush ? '0 : wptr;
        free      = CW'(DEPTH) - count_mid;
        n_acc     = (CW'(push_n) > free) ? free : CW'(push_n);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_MAX; i++) begin
            if (CW'(i) < n_acc) mem[wbase + AW'(i)] <= push_data[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            rptr  <= rptr_mid;
            wptr  <= wbase + AW'(n_acc);
            count <= count_mid + n_acc;
        end
    end

    assign avail   = (count != '0);
    assign rd_data = avail ? mem[rptr] : 8'h00;

    p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && !pop && !flush) |=> (count == CW'(DEPTH)));
    p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && pop && push_n == '0 && !flush) |=> !avail);
    p_pop_one_r7: assert property (@(posedge clk) disable iff (rst)
        (count > CW'(1) && pop && !flush && push_n == '0) |=> avail);

endmodule

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder
    import kbd_resp_pkg::*;
#(
    parameter int unsigned DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       key_valid,
    input  logic [7:0] key_byte,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       byte_avail
);
    localparam int unsigned PUSH_MAX = REPLY_MAX + 1;
    localparam int unsigned PW       = $clog2(PUSH_MAX + 1);

    reply_t                   rep;
    keyout_t                  kout;
    logic [PW-1:0]            push_n;
    logic [PUSH_MAX-1:0][7:0] push_data;
    logic                     cmd_go;

    assign cmd_go = cmd_valid && tx_en;

    kbd_cmd_decode u_dec (
        .clk (clk),
        .rst (rst),
        .go  (cmd_go),
        .cmd (cmd_byte),
        .rep (rep)
    );

    kbd_key_xlate u_key (
        .clk   (clk),
        .rst   (rst),
        .valid (key_valid),
        .raw   (key_byte),
        .kout  (kout)
    );

    // R11: reply bytes occupy the first slots, the key code follows them
    assign push_n = PW'(rep.n) + PW'(kout.valid);

    for (genvar g = 0; g < PUSH_MAX; g++) begin : g_slot
        if (g < REPLY_MAX) begin : g_rep
            assign push_data[g] = (RN_W'(g) < rep.n) ? rep.bytes[g] : kout.code;
        end else begin : g_key
            assign push_data[g] = kout.code;
        end
    end

    kbd_byte_queue #(
        .DEPTH    (DEPTH),
        .PUSH_MAX (PUSH_MAX)
    ) u_q (
        .clk       (clk),
        .rst       (rst),
        .flush     (rep.flush),
        .pop       (rd_pop),
        .push_n    (push_n),
        .push_data (push_data),
        .rd_data   (rd_data),
        .avail     (byte_avail)
    );

    p_idle_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !tx_en) |-> !rep.flush);

endmodule

// File: tb/kbd_cmd_responder_test.sv
module kbd_cmd_responder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       key_valid = 1'b0;
    logic [7:0] key_byte = 8'h00;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       byte_avail;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    kbd_cmd_responder uut (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .key_valid  (key_valid),
        .key_byte   (key_byte),
        .rd_pop     (rd_pop),
        .rd_data    (rd_data),
        .byte_avail (byte_avail)
    );

    // ---------------- reference model ----------------
    logic [7:0] mq [$];
    logic       m_led, m_ext;
    logic [1:0] m_caps, m_num;

    function automatic void m_clear();
        mq.delete();
        m_led = 0; m_ext = 0; m_caps = 0; m_num = 0;
    endfunction

    function automatic void m_push(logic [7:0] b);
        if (mq.size() < 256) mq.push_back(b);
    endfunction

    function automatic void m_cmd(logic [7:0] c);
        if (m_led) begin
            m_led = 0;
        end else if (c == 8'h01) begin
            mq.delete(); m_push(8'hFF); m_push(8'h04); m_push(8'h7F);
        end else if (c == 8'h07 || c == 8'h0F) begin
            mq.delete(); m_push(8'hFE); m_push(8'h00);
        end else if (c == 8'h0E) begin
            m_led = 1;
        end
    endfunction

    function automatic void m_key(logic [7:0] k);
        int v;
        if (k == 8'hE0) begin m_ext = 1; return; end
        if (k == 8'h3A) begin m_caps ^= 2'd1; if (m_caps == 2) return; end
        if (k == 8'hBA) begin m_caps ^= 2'd2; if (m_caps == 3) return; end
        if (k == 8'h45) begin m_num  ^= 2'd1; if (m_num  == 2) return; end
        if (k == 8'hC5) begin m_num  ^= 2'd2; if (m_num  == 3) return; end
        if (m_ext) v = (int'(k[6:0]) * 3 + 17) % 128;
        else       v = (int'(k[6:0]) * 5 + 3) % 128;
        m_ext = 0;
        m_push({k[7], 7'(v)});
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic compare(string tag);
        check({tag, " data"}, rd_data, (mq.size() != 0) ? mq[0] : 8'h00);
        check({tag, " avail"}, {7'd0, byte_avail}, {7'd0, mq.size() != 0});
    endtask

    // one cycle: drive at negedge, compare settled outputs, apply edge
    task automatic step(string tag, logic te, logic cv, logic [7:0] c,
                        logic kv, logic [7:0] k, logic p);
        @(negedge clk);
        tx_en = te; cmd_valid = cv; cmd_byte = c;
        key_valid = kv; key_byte = k; rd_pop = p;
        #1;
        compare(tag);
        @(posedge clk);
        if (p && mq.size() != 0) void'(mq.pop_front());
        if (cv && te) m_cmd(c);
        if (kv) m_key(k);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; cmd_valid = 0; key_valid = 0; rd_pop = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_clear();
    endtask

    // vector: [24:21] req, [20] tx_en, [19] cmd_valid, [18:11] cmd,
    //         [10] key_valid, [9:2] key, [1] pop, [0] unused
    localparam int NV = 24;
    localparam logic [24:0] VEC [NV] = '{
        {4'd2,  1'b1, 1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0}, // R2 reset reply
        {4'd7,  1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0}, // R7 pop
        {4'd7,  1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0}, // R7 pop
        {4'd8,  1'b1, 1'b0, 8'h00, 1'b1, 8'h10, 1'b0, 1'b0}, // R8 key
        {4'd3,  1'b1, 1'b1, 8'h07, 1'b0, 8'h00, 1'b0, 1'b0}, // R3 flush
        {4'd5,  1'b1, 1'b1, 8'h33, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 unknown
        {4'd5,  1'b0, 1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 tx off
        {4'd4,  1'b1, 1'b1, 8'h0E, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 arm
        {4'd4,  1'b1, 1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 swallowed
        {4'd8,  1'b1, 1'b0, 8'h00, 1'b1, 8'h90, 1'b0, 1'b0}, // R8 release
        {4'd9,  1'b1, 1'b0, 8'h00, 1'b1, 8'hE0, 1'b0, 1'b0}, // R9 prefix
        {4'd9,  1'b1, 1'b0, 8'h00, 1'b1, 8'h48, 1'b0, 1'b0}, // R9 ext key
        {4'd8,  1'b1, 1'b0, 8'h00, 1'b1, 8'h48, 1'b0, 1'b0}, // R8 back to std
        {4'd11, 1'b1, 1'b1, 8'h0F, 1'b1, 8'h7F, 1'b0, 1'b0}, // R11 same cycle
        {4'd10, 1'b1, 1'b0, 8'h00, 1'b1, 8'h3A, 1'b0, 1'b0}, // R10 caps
        {4'd10, 1'b1, 1'b0, 8'h00, 1'b1, 8'hBA, 1'b0, 1'b0},
        {4'd10, 1'b1, 1'b0, 8'h00, 1'b1, 8'h3A, 1'b0, 1'b0},
        {4'd10, 1'b1, 1'b0, 8'h00, 1'b1, 8'hBA, 1'b0, 1'b0},
        {4'd10, 1'b1, 1'b0, 8'h00, 1'b1, 8'h45, 1'b1, 1'b0}, // R10 num
        {4'd10, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC5, 1'b1, 1'b0},
        {4'd10, 1'b1, 1'b0, 8'h00, 1'b1, 8'h45, 1'b1, 1'b0},
        {4'd10, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC5, 1'b1, 1'b0},
        {4'd7,  1'b1, 1'b0, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b0}, // R7 pop+push
        {4'd7,  1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        m_clear();
        do_reset();

        // R1: reset state
        #1;
        check("R1 avail", {7'd0, byte_avail}, 8'h00);
        check("R1 data", rd_data, 8'h00);

        foreach (VEC[i]) begin
            logic [24:0] v;
            v = VEC[i];
            step($sformatf("R%0d vec%0d", v[24:21], i), v[20], v[19], v[18:11],
                 v[10], v[9:2], v[1]);
        end

        // drain, then a read of the empty queue (R7, R6)
        while (mq.size() != 0) step("R7 drain", 1, 0, 8'h00, 0, 8'h00, 1);
        step("R6 empty pop", 1, 0, 8'h00, 0, 8'h00, 1);
        step("R6 after empty pop", 1, 0, 8'h00, 0, 8'h00, 0);

        // R6: fill past capacity, extra bytes dropped
        for (int i = 0; i < 260; i++)
            step("R6 fill", 1, 0, 8'h00, 1, {1'b0, 7'(i % 64)}, 0);
        check("R6 full size", 8'(mq.size() - 1), 8'hFF);
        while (mq.size() != 0) step("R6 drain", 1, 0, 8'h00, 0, 8'h00, 1);
        step("R6 drained", 1, 0, 8'h00, 0, 8'h00, 0);

        // R1: reset mid-activity clears queue, LED flag, escape, lock modes
        step("R1 prep", 1, 1, 8'h0E, 1, 8'hE0, 0);
        step("R1 prep", 1, 0, 8'h00, 1, 8'h3A, 0);
        do_reset();
        step("R1 after reset", 1, 1, 8'h01, 0, 8'h00, 0);
        step("R1 led cleared", 1, 0, 8'h00, 1, 8'h48, 0);
        step("R1 lock cleared", 1, 0, 8'h00, 1, 8'h3A, 0);
        while (mq.size() != 0) step("R1 drain", 1, 0, 8'h00, 0, 8'h00, 1);
        step("R1 end", 1, 0, 8'h00, 0, 8'h00, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule